// File: doc/BRIEF.md
# Aligned Ratio Clock-Enable Generator

This block turns one master clock into three clock-enable streams: one for the processor core, one for the AXI fabric and one for the AHB/APB peripheral bus. A six-bit ratio register holds three two-bit power-of-two codes, one per stream. Every stream is decoded from a single free-running phase counter, so the edges of the three streams always line up. Logic in the master clock domain uses each enable as a one-cycle qualifier. For example, with an 80 MHz master clock and ratios of 1, 2 and 4, the streams run at 80, 40 and 20 MHz.

Software writes the ratio register at any time. The accepted value is held in a staging register that can be read back at once. The three dividers take up the staged value together, only at the moment the phase counter wraps to zero. Dividing the peripheral bus by one is not allowed. A write that asks for it keeps the old bus code, still updates the other two codes, and raises a sticky error flag. After reset all three streams run at divide-by-8.

Top module: `clk_ratio_gen`

## Requirements
- R1: Each two-bit code selects a ratio: 00 gives divide-by-1, 01 divide-by-2, 10 divide-by-4 and 11 divide-by-8. A stream with ratio N is high for exactly one cycle in every N cycles, and is high on every cycle for N=1. The core code is bits [1:0], the AXI code is bits [3:2] and the bus code is bits [5:4].
- R2: After reset the readback value is 0x3F, the error flag is 0, and each stream pulses once in every 8 cycles.
- R3: A write whose bits [5:4] are 00 leaves the bus code unchanged and still loads bits [3:0]. The readback bus code is never 00.
- R4: A write whose bits [5:4] are 00 sets the error flag on the next cycle. The flag stays set through later writes and is cleared only by reset.
- R5: A write made partway through an 8-cycle period does not change any stream until the phase counter next returns to zero. The new ratios apply from that cycle onward.
- R6: A write in the last cycle of a period, with the counter at 7, takes effect from the very next cycle, which is the start of the new period.
- R7: In the first cycle of every period all three streams are high together. Each stream is high exactly when the phase counter is a multiple of its ratio.
- R8: A write that is accepted appears on the readback port in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the ratio register |
| cfg_wdata | input | 6 | Write data: core [1:0], AXI [3:2], bus [5:4] |
| cfg_rd | output | 6 | Staged ratio register value |
| cfg_err | output | 1 | Sticky flag for a rejected bus divide-by-1 request |
| cpu_en | output | 1 | Core clock-enable pulse |
| axi_en | output | 1 | AXI clock-enable pulse |
| bus_en | output | 1 | AHB/APB clock-enable pulse |

## Verification
The hardest case to reach from the ports is a ratio write that lands in a known phase of the hidden counter, either mid-period or in the final wrap cycle. The bench first keeps the bus stream at divide-by-8. That makes every bus pulse mark counter zero, so the bench can lock onto that pulse and count negedges to place the write strobe at phase 1 or phase 7. It then watches the core stream to see the exact cycle in which the new ratio appears. Rejected bus writes are given after different previous bus codes, so the value that is kept is not always the reset value.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

    // The largest ratio code selects a divider of 2**(2**FIELD_W - 1).
    // The phase counter therefore needs (2**FIELD_W - 1) bits.
    function automatic int phase_width(input int field_w);
        return (1 << field_w) - 1;
    endfunction

    // Number of ratio fields in the register: core, AXI and bus.
    localparam int NUM_STREAMS = 3;

    // Index of the field that may never select divide-by-1.
    localparam int BUS_STREAM = 2;

endpackage

// File: rtl/ratio_cfg_reg.sv
module ratio_cfg_reg
    import clk_ratio_pkg::*;
#(
    parameter int FIELD_W = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [FIELD_W*NUM_STREAMS-1:0]     wdata,
    output logic [FIELD_W*NUM_STREAMS-1:0]     cfg_next,
    output logic [FIELD_W*NUM_STREAMS-1:0]     cfg_cur,
    output logic                               err
);

    localparam int CFG_W  = FIELD_W * NUM_STREAMS;
    localparam int BUS_LO = FIELD_W * BUS_STREAM;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             err;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int f = 0; f < NUM_STREAMS; f++) begin
                if (f == BUS_STREAM && wdata[BUS_LO +: FIELD_W] == '0) begin
                    // A bus divide-by-1 request is refused: keep the old code and flag it.
                    st_d.err = 1'b1;
                end else begin
                    st_d.cfg[f*FIELD_W +: FIELD_W] = wdata[f*FIELD_W +: FIELD_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= '1;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_next = st_d.cfg;
    assign cfg_cur  = st_q.cfg;
    assign err      = st_q.err;

endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] phase,
    output logic             at_last
);

    typedef struct packed {
        logic [CNT_W-1:0] phase;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase   = st_q.phase;
    assign at_last = (st_q.phase == '1);

endmodule

// File: rtl/enable_decode.sv
module enable_decode #(
    parameter int FIELD_W = 2,
    parameter int CNT_W   = 3
) (
    input  logic [FIELD_W-1:0] code,
    input  logic [CNT_W-1:0]   phase,
    output logic               en
);

    logic [CNT_W-1:0] low_mask;

    always_comb begin
        low_mask = '0;
        for (int b = 0; b < CNT_W; b++) begin
            if (b < int'(code)) begin
                low_mask[b] = 1'b1;
            end
        end
        en = ((phase & low_mask) == '0);
    end

endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
    import clk_ratio_pkg::*;
#(
    parameter int FIELD_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [FIELD_W*NUM_STREAMS-1:0] cfg_wdata,
    output logic [FIELD_W*NUM_STREAMS-1:0] cfg_rd,
    output logic                           cfg_err,
    output logic                           cpu_en,
    output logic                           axi_en,
    output logic                           bus_en
);

    localparam int CFG_W = FIELD_W * NUM_STREAMS;
    localparam int CNT_W = phase_width(FIELD_W);

    logic [CFG_W-1:0]    cfg_next;
    logic [CNT_W-1:0]    cnt;
    logic                wrap;
    logic [NUM_STREAMS-1:0] en_vec;

    typedef struct packed {
        logic [CFG_W-1:0] act;
    } act_state_t;

    act_state_t st_d, st_q;
    logic [CFG_W-1:0] act;

    ratio_cfg_reg #(.FIELD_W(FIELD_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .cfg_next (cfg_next),
        .cfg_cur  (cfg_rd),
        .err      (cfg_err)
    );

    phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (cnt),
        .at_last (wrap)
    );

    // Ratios in use change together, only as the counter rolls over to zero.
    always_comb begin
        st_d = st_q;
        if (wrap) begin
            st_d.act = cfg_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign act = st_q.act;

    generate
        for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
            enable_decode #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_dec (
                .code  (act[s*FIELD_W +: FIELD_W]),
                .phase (cnt),
                .en    (en_vec[s])
            );
        end
    endgenerate

    assign cpu_en = en_vec[0];
    assign axi_en = en_vec[1];
    assign bus_en = en_vec[BUS_STREAM];

endmodule

// File: rtl/clk_ratio_chk.sv
module clk_ratio_chk
    import clk_ratio_pkg::*;
#(
    parameter int FIELD_W = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_we,
    input logic [FIELD_W*NUM_STREAMS-1:0] cfg_wdata,
    input logic [FIELD_W*NUM_STREAMS-1:0] cfg_rd,
    input logic                           cfg_err,
    input logic                           cpu_en,
    input logic                           axi_en,
    input logic                           bus_en,
    input logic [phase_width(FIELD_W)-1:0] cnt,
    input logic [FIELD_W*NUM_STREAMS-1:0] act
);

    localparam int BUS_LO = FIELD_W * BUS_STREAM;
    localparam int CNT_W  = phase_width(FIELD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    AST_BUS_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd[BUS_LO +: FIELD_W] != '0);  // R3

    AST_REJECT_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[BUS_LO +: FIELD_W] == '0)
        |=> cfg_rd[BUS_LO +: FIELD_W] == $past(cfg_rd[BUS_LO +: FIELD_W]));  // R3

    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[BUS_LO +: FIELD_W] == '0) |=> cfg_err);  // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);  // R4

    AST_RATIO_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> $past(cnt) == CNT_LAST);  // R5

    AST_ALIGNED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (cpu_en && axi_en && bus_en));  // R7

    AST_ACCEPT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[BUS_LO +: FIELD_W] != '0) |=> cfg_rd == $past(cfg_wdata));  // R8

endmodule

bind clk_ratio_gen clk_ratio_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rd    (cfg_rd),
    .cfg_err   (cfg_err),
    .cpu_en    (cpu_en),
    .axi_en    (axi_en),
    .bus_en    (bus_en),
    .cnt       (cnt),
    .act       (act)
);

// File: tb/sim_clk_ratio_gen.sv
`timescale 1ns/1ps
module sim_clk_ratio_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic [5:0] cfg_rd;
    logic       cfg_err;
    logic       cpu_en, axi_en, bus_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    clk_ratio_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rd    (cfg_rd),
        .cfg_err   (cfg_err),
        .cpu_en    (cpu_en),
        .axi_en    (axi_en),
        .bus_en    (bus_en)
    );

    // {write data, expected readback, expected error flag}
    localparam logic [12:0] VEC [0:5] = '{
        {6'h24, 6'h24, 1'b0},
        {6'h1B, 6'h1B, 1'b0},
        {6'h39, 6'h39, 1'b0},
        {6'h0E, 6'h3E, 1'b1},
        {6'h15, 6'h15, 1'b1},
        {6'h00, 6'h10, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [5:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic count8(output int c0, output int c1, output int c2);
        c0 = 0; c1 = 0; c2 = 0;
        repeat (8) begin
            @(negedge clk);
            c0 += int'(cpu_en);
            c1 += int'(axi_en);
            c2 += int'(bus_en);
        end
    endtask

    // Needs the bus stream at divide-by-8: returns at a negedge where the counter is zero.
    task automatic sync0();
        do @(negedge clk); while (!bus_en);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c0, c1, c2;
        repeat (3) @(negedge clk);
        chk("R2 reset readback", int'(cfg_rd), 6'h3F);
        chk("R2 reset err", int'(cfg_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        count8(c0, c1, c2);
        chk("R2 cpu /8", c0, 1);
        chk("R2 axi /8", c1, 1);
        chk("R2 bus /8", c2, 1);

        // R5: write at phase 1, no effect until phase 0
        sync0();
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 6'h3C;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R8 readback after write", int'(cfg_rd), 6'h3C);
        c0 = int'(cpu_en);
        repeat (5) begin
            @(negedge clk);
            c0 += int'(cpu_en);
        end
        chk("R5 old ratio held mid-period", c0, 0);
        @(negedge clk);
        chk("R7 all high at period start", int'({cpu_en, axi_en, bus_en}), 7);
        @(negedge clk);
        chk("R5 new ratio after wrap", int'(cpu_en), 1);

        // R6: write in the wrap cycle takes effect at once
        sync0();
        repeat (7) @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 6'h3D;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R6 phase0 cpu", int'(cpu_en), 1);
        @(negedge clk);
        chk("R6 phase1 cpu /2", int'(cpu_en), 0);
        @(negedge clk);
        chk("R6 phase2 cpu /2", int'(cpu_en), 1);

        // R7: slower stream high implies faster streams high
        write_cfg(6'h39);
        repeat (9) @(negedge clk);
        c0 = 0;
        repeat (16) begin
            @(negedge clk);
            if (bus_en && !(axi_en && cpu_en)) c0++;
            if (axi_en && !cpu_en) c0++;
        end
        chk("R7 nested alignment", c0, 0);

        // Table: R1 ratios, R3 rejection, R4 sticky flag
        for (int i = 0; i < 6; i++) begin
            logic [5:0] wd, ex;
            logic       er;
            {wd, ex, er} = VEC[i];
            write_cfg(wd);
            chk("R3 readback", int'(cfg_rd), int'(ex));
            chk("R4 err flag", int'(cfg_err), int'(er));
            repeat (9) @(negedge clk);
            count8(c0, c1, c2);
            chk("R1 cpu pulses", c0, 8 >> ex[1:0]);
            chk("R1 axi pulses", c1, 8 >> ex[3:2]);
            chk("R1 bus pulses", c2, 8 >> ex[5:4]);
        end

        // R4: only reset clears the flag
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R4 err cleared by reset", int'(cfg_err), 0);
        chk("R2 readback after reset", int'(cfg_rd), 6'h3F);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule